// File: doc/BRIEF.md
# Double-Buffered LED Column Latch Array

This block is the panel side of a cascaded monochrome LED wall. A host reaches it over a 16-bit memory-mapped write bus. The wall is a grid of identical 64×32 modules. Each module holds sixteen 8-bit column latches: eight serve the upper sixteen rows and eight serve the lower sixteen rows. Modules sit side by side in a row, and rows of modules are stacked into vertical levels.

The host writes in two steps. When chip-select falls, the block captures the bus address, the data word and a separate 3-bit level select. When write-enable falls later in the same cycle of chip-select, the block stores the captured bytes into the front rank of latches. The low byte goes to vertical level L and the high byte goes to level L+1. Both bytes land at the same module and the same latch index.

A transfer strobe copies the whole front rank into the back rank in one step. The back rank drives the columns, so the host can fill the next row's data without disturbing the image shown. A 4-bit row code selects one of sixteen row lines, and that line is shared by every module.

Top module: `led_wall_latches`

## Requirements
- R1: While reset is low, and after it is released, both latch ranks hold zero. After reset, `col_data` reads all zeros and `row_en` reads zero until the first clock edge outside reset.
- R2: A write stores the low data byte at latch k = `bus_addr[4:1]` of module m = `bus_addr[8:5]` in level L = `lvl_sel`. That latch appears at `col_data` byte index (L·NUM_MODS + m)·16 + k, which is bit field [idx·8 +: 8].
- R3: The same write stores the high data byte at the same module and latch in level L+1, at byte index idx + NUM_MODS·16.
- R4: Address, data and level are captured on the clock edge that first samples `cs_n` low. Later changes on those inputs during the same access are ignored. The front rank is written only on the edge that first samples `we_n` low while `cs_n` is low, and only after the capture. A `we_n` pulse with `cs_n` high writes nothing.
- R5: `col_data` changes only on the clock edge that follows a sampled rising edge of `xfer`. At that edge the back rank takes the whole front rank as it stood before that edge. Front-rank writes before that edge leave `col_data` unchanged.
- R6: A write whose module index m is not below NUM_MODS changes no latch.
- R7: Each byte whose target level is not below NUM_LVLS is dropped, while the other byte of the same write is still stored. In particular, when L = NUM_LVLS−1, only the low byte is stored.
- R8: Outside reset, `row_en` equals 1 shifted left by the `row_code` sampled at the previous clock edge, so exactly one line is high.
- R9: Holding `xfer` high performs a single copy. Writes made while it stays high do not reach `col_data` until `xfer` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; its falling edge captures the access |
| we_n | input | 1 | Active-low write enable; its falling edge loads the front rank |
| bus_addr | input | 8 | Word address bits [8:1]: latch index [4:1], module index [8:5] |
| bus_data | input | 16 | Write data; low byte to level L, high byte to level L+1 |
| lvl_sel | input | 3 | Vertical level L of the low byte |
| xfer | input | 1 | Transfer strobe; its rising edge copies the front rank to the back rank |
| row_code | input | 4 | Row line to drive |
| col_data | output | NUM_LVLS·NUM_MODS·128 | Flattened back-rank column data |
| row_en | output | 16 | One-hot row enable |

## Verification
The assertions assume the host follows the bus protocol for every access. Each access drops `cs_n` at least one clock before `we_n`, and raises both lines together. The assertions also assume `xfer` is held at a defined level from time zero.

The stimulus keeps inside these rules by driving every access through one task. That task spaces chip-select, write-enable and release one clock apart. The bench makes a single deliberate exception: a lone `we_n` pulse with chip-select high, used to show that such a pulse has no effect. `xfer` is driven only between accesses, except in the hold-high case of R9.

// File: rtl/led_wall_latches.sv
module led_wall_latches #(
  parameter int NUM_MODS = 2,
  parameter int NUM_LVLS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cs_n,
  input  logic                           we_n,
  input  logic [8:1]                     bus_addr,
  input  logic [15:0]                    bus_data,
  input  logic [2:0]                     lvl_sel,
  input  logic                           xfer,
  input  logic [3:0]                     row_code,
  output logic [NUM_LVLS*NUM_MODS*128-1:0] col_data,
  output logic [15:0]                    row_en
);
  localparam int PER_MOD = 16;
  localparam int NB      = NUM_LVLS * NUM_MODS * PER_MOD;
  localparam int LVL_STEP = NUM_MODS * PER_MOD;

  logic        cs_q, we_q, xf_q, cap_vld;
  logic [3:0]  cap_mod, cap_k;
  logic [2:0]  cap_lvl;
  logic [15:0] cap_dat;
  logic [7:0]  r1 [NB];
  logic [7:0]  r2 [NB];
  logic [NB*8-1:0] r1_flat;

  wire cs_fall = cs_q & ~cs_n;
  wire we_fall = we_q & ~we_n & ~cs_n & cap_vld;
  wire xf_rise = ~xf_q & xfer;

  int  idx_lo, idx_hi;
  logic lo_ok, hi_ok;

  always_comb begin
    idx_lo = (int'(cap_lvl) * NUM_MODS + int'(cap_mod)) * PER_MOD + int'(cap_k);
    idx_hi = idx_lo + LVL_STEP;
    lo_ok  = (int'(cap_mod) < NUM_MODS) && (int'(cap_lvl) < NUM_LVLS);
    hi_ok  = (int'(cap_mod) < NUM_MODS) && (int'(cap_lvl) + 1 < NUM_LVLS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      we_q    <= 1'b1;
      xf_q    <= 1'b0;
      cap_vld <= 1'b0;
      cap_mod <= '0;
      cap_k   <= '0;
      cap_lvl <= '0;
      cap_dat <= '0;
      row_en  <= '0;
      for (int i = 0; i < NB; i++) begin
        r1[i] <= '0;
        r2[i] <= '0;
      end
    end else begin
      cs_q   <= cs_n;
      we_q   <= we_n;
      xf_q   <= xfer;
      row_en <= 16'd1 << row_code;
      if (cs_n) cap_vld <= 1'b0;
      else if (cs_fall) begin
        cap_vld <= 1'b1;
        cap_k   <= bus_addr[4:1];
        cap_mod <= bus_addr[8:5];
        cap_lvl <= lvl_sel;
        cap_dat <= bus_data;
      end
      for (int i = 0; i < NB; i++) begin
        if (we_fall && lo_ok && i == idx_lo) r1[i] <= cap_dat[7:0];
        if (we_fall && hi_ok && i == idx_hi) r1[i] <= cap_dat[15:8];
        if (xf_rise) r2[i] <= r1[i];
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign col_data[g*8 +: 8] = r2[g];
    assign r1_flat[g*8 +: 8]  = r1[g];
  end
endmodule

// File: rtl/led_wall_checker.sv
module led_wall_checker #(
  parameter int DW = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          we_n,
  input logic          xfer,
  input logic [3:0]    row_code,
  input logic [15:0]   row_en,
  input logic [DW-1:0] col_data,
  input logic [DW-1:0] r1_flat
);
  assert_row_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $onehot(row_en));

  assert_row_follows_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> row_en == (16'd1 << $past(row_code)));

  assert_cols_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(xfer) && !$past(xfer, 2))) |-> $stable(col_data));

  assert_front_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(r1_flat)) |-> ($past(!we_n) && $past(!cs_n)));
endmodule

bind led_wall_latches led_wall_checker #(.DW(NB*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .xfer(xfer),
  .row_code(row_code), .row_en(row_en), .col_data(col_data), .r1_flat(r1_flat)
);

// File: tb/sim_led_wall_latches.sv
`timescale 1ns/1ps
module sim_led_wall_latches;
  localparam int NM = 2, NL = 4, NB = NL*NM*16, DW = NB*8;

  logic clk = 0, rst_n = 0, cs_n = 1, we_n = 1, xfer = 0;
  logic [8:1] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic [2:0] lvl_sel = '0;
  logic [3:0] row_code = '0;
  logic [DW-1:0] col_data;
  logic [15:0] row_en;

  logic [7:0] m1 [NB];
  logic [7:0] m2 [NB];
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  led_wall_latches #(.NUM_MODS(NM), .NUM_LVLS(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .lvl_sel(lvl_sel), .xfer(xfer), .row_code(row_code),
    .col_data(col_data), .row_en(row_en));

  task automatic chk_cols(string tag);
    int bad = -1;
    for (int i = 0; i < NB; i++)
      if (col_data[i*8 +: 8] !== m2[i] && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      errs++;
      $display("FAIL %s byte %0d actual %h expected %h", tag, bad, col_data[bad*8 +: 8], m2[bad]);
    end
  endtask

  task automatic wr(int lvl, int md, int k, logic [15:0] d);
    int idx;
    @(negedge clk);
    bus_addr = {4'(md), 4'(k)}; bus_data = d; lvl_sel = 3'(lvl); cs_n = 0;
    @(negedge clk); we_n = 0;
    @(negedge clk); we_n = 1; cs_n = 1;
    idx = (lvl*NM + md)*16 + k;
    if (md < NM && lvl < NL) m1[idx] = d[7:0];
    if (md < NM && lvl + 1 < NL) m1[idx + NM*16] = d[15:8];
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer = 1;
    @(negedge clk); xfer = 0;
    for (int i = 0; i < NB; i++) m2[i] = m1[i];
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m1[i] = 0; m2[i] = 0; end
    repeat (3) @(negedge clk);
    chk_cols("R1");
    checks++;
    if (row_en !== 16'd0) begin errs++; $display("FAIL R1 row_en actual %h expected 0000", row_en); end
    rst_n = 1;

    // R8 row sweep
    for (int r = 0; r < 16; r++) begin
      row_code = 4'(r);
      @(negedge clk);
      checks++;
      if (row_en !== (16'd1 << r)) begin
        errs++; $display("FAIL R8 row %0d actual %h expected %h", r, row_en, 16'd1 << r);
      end
    end

    // R2 R3 R6 R7 sweep over levels incl. out of range, modules incl. out of range
    for (int lv = 0; lv < 6; lv++) begin
      for (int md = 0; md < 4; md++)
        for (int k = 0; k < 16; k++)
          wr(lv, md, k, {8'(k*3 + md*37 + lv*91) ^ 8'h3C, 8'(k + 16*md + 64*lv) ^ 8'hA5});
      chk_cols("R5 hold before xfer");
      pulse_xfer();
      chk_cols(lv == NL-1 ? "R7 top level" : (lv >= NL ? "R6/R7 out of range" : "R2/R3 placement"));
    end

    // R4 capture at cs fall: late change of bus inputs ignored
    @(negedge clk);
    bus_addr = {4'd1, 4'd5}; bus_data = 16'h1234; lvl_sel = 3'd1; cs_n = 0;
    @(negedge clk); bus_addr = {4'd0, 4'd2}; bus_data = 16'hFFFF; lvl_sel = 3'd0; we_n = 0;
    @(negedge clk); we_n = 1; cs_n = 1;
    m1[(1*NM + 1)*16 + 5] = 8'h34; m1[(2*NM + 1)*16 + 5] = 8'h12;
    pulse_xfer();
    chk_cols("R4 capture");

    // R4 we pulse without cs
    @(negedge clk); bus_data = 16'h0F0F; bus_addr = '0; lvl_sel = 0; we_n = 0;
    @(negedge clk); we_n = 1;
    pulse_xfer();
    chk_cols("R4 no cs");

    // R9 xfer held high
    @(negedge clk); xfer = 1;
    @(negedge clk);
    for (int i = 0; i < NB; i++) m2[i] = m1[i];
    wr(0, 0, 0, 16'hBEEF);
    chk_cols("R9 held high");
    @(negedge clk); xfer = 0;
    pulse_xfer();
    chk_cols("R9 re-raise");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule